// File: doc/BRIEF.md
# DMA-Requesting Parallel Bus Master

This block is a bus master for a shared parallel bus. It must win the bus from an arbiter through a request/grant handshake before it drives any cycle. A one-cycle pulse on the write trigger starts a batch of byte write cycles. Each write goes to a distinct location of a 64-byte slave memory and carries a byte from a small fixed pattern table. A pulse on the read trigger starts a batch of read cycles to the same locations. Each returned byte is compared with the byte that was written there.

Each transfer follows the same sequence. The address is placed and the address strobe raised. One clock later the write or read command is raised, and one clock after that the data strobe. All of these stay up until the slave answers with ready, and then the strobes drop. On writes the master enables its data outputs only while the data strobe is up.

When a batch ends, the master releases its bus request and raises a done flag. It also raises an error flag if any read-back byte mismatched or a transfer timed out. A transfer with no ready after 16 clocks of data strobe is aborted, and the bus is released. A read trigger is ignored until a write batch has completed cleanly.

Top module: `dma_bus_master`

## Requirements
- R1: The bus request rises only after a trigger is accepted. The address strobe stays low until a grant has been seen, and no strobe is ever high while the bus request is low.
- R2: Each transfer raises the address strobe first. The command (write or read) follows one clock later and the data strobe one clock after that. The data strobe stays up until ready is seen or the timeout aborts.
- R3: In the clock after the data strobe meets ready, the address strobe, data strobe, write and read are all low.
- R4: The data output enable is high only while the data strobe and write are both high. Write and read are never high together.
- R5: A write batch performs three writes in this order: address 0x0005 with data 0xA5, address 0x0012 with data 0x3C, and address 0x002A with data 0xF0.
- R6: A read batch reads 0x0005, 0x0012 and 0x002A in that order. The error flag is set if any returned byte differs from the byte written to that address.
- R7: Every address driven while the address strobe is high is below 64.
- R8: When a batch ends, the bus request falls and the done flag is high. A new batch clears the done and error flags when it starts.
- R9: If ready does not arrive, the data strobe stays up for exactly 16 clocks. The transfer is then aborted: error and done are set, and the bus request is released.
- R10: A read trigger is ignored (the bus request stays low) until a write batch has completed without a timeout. A timed-out write batch withdraws that permission.
- R11: After reset the bus request, all strobes, the output enable, done and error are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| do_write_i | input | 1 | Pulse that starts a write batch |
| do_read_i | input | 1 | Pulse that starts a read-back batch |
| bus_req_o | output | 1 | Bus request to the arbiter |
| bus_gnt_i | input | 1 | Bus grant from the arbiter |
| addr_o | output | 16 | Address bus |
| data_out_o | output | 8 | Write data toward the bus |
| data_in_i | input | 8 | Read data from the bus |
| data_oe_o | output | 1 | Enable for the write data drivers |
| as_o | output | 1 | Address strobe |
| wr_o | output | 1 | Write command |
| rd_o | output | 1 | Read command |
| ds_o | output | 1 | Data strobe |
| rdy_i | input | 1 | Slave ready |
| done_o | output | 1 | Batch finished |
| err_o | output | 1 | Read-back mismatch or timeout in the last batch |

## Verification
On every clock, the assertions check the strobe ordering and the release after ready. They also check that the output enable stays inside a write data strobe, that addresses stay in range, that done is high when the request falls, and that no data strobe outlasts the 16-clock limit. The bench scenarios are needed to show the order of addresses and bytes in each batch and the mismatch detection against a corrupted slave byte. They also show the exact 16-clock abort, the wait for a late grant, and that a read trigger is refused before a clean write batch and after a timed-out one.

// File: rtl/bm_pkg.sv
package bm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_ADDR,
    ST_CMD,
    ST_STRB,
    ST_NEXT
  } bm_state_t;

  // Pattern table: entries 0..2 fixed, further entries derived.
  function automatic int unsigned pat_addr(input int unsigned i);
    case (i)
      0: return 32'h05;
      1: return 32'h12;
      2: return 32'h2A;
      default: return (i * 11 + 3) % 64;
    endcase
  endfunction

  function automatic int unsigned pat_data(input int unsigned i);
    case (i)
      0: return 32'hA5;
      1: return 32'h3C;
      2: return 32'hF0;
      default: return (i * 37 + 1) % 256;
    endcase
  endfunction

endpackage

// File: rtl/bm_datapath.sv
module bm_datapath #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int N_CYC  = 3,
  parameter int TMO    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              idx_clr,
  input  logic              idx_inc,
  input  logic              tmo_clr,
  input  logic              tmo_inc,
  input  logic [DATA_W-1:0] data_in,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata,
  output logic              last,
  output logic              tmo_hit,
  output logic              miss
);
  import bm_pkg::*;

  localparam int IDX_W = (N_CYC > 1) ? $clog2(N_CYC) : 1;
  localparam int TMO_W = $clog2(TMO + 1);

  logic [IDX_W-1:0] idx_q;
  logic [TMO_W-1:0] tmo_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
      addr  <= '0;
      wdata <= '0;
    end else if (idx_clr) begin
      idx_q <= '0;
      addr  <= ADDR_W'(pat_addr(0));
      wdata <= DATA_W'(pat_data(0));
    end else if (idx_inc) begin
      idx_q <= idx_q + 1'b1;
      addr  <= ADDR_W'(pat_addr(int'(idx_q) + 1));
      wdata <= DATA_W'(pat_data(int'(idx_q) + 1));
    end
  end

  always_ff @(posedge clk) begin
    if (rst || tmo_clr) tmo_q <= '0;
    else if (tmo_inc)   tmo_q <= tmo_q + 1'b1;
  end

  assign last    = (idx_q == IDX_W'(N_CYC - 1));
  assign tmo_hit = (tmo_q == TMO_W'(TMO - 1));
  assign miss    = (data_in != wdata);

endmodule

// File: rtl/bm_ctrl.sv
module bm_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic start_wr,
  input  logic start_rd,
  input  logic gnt,
  input  logic rdy,
  input  logic last,
  input  logic tmo_hit,
  input  logic miss,
  output logic idx_clr,
  output logic idx_inc,
  output logic tmo_clr,
  output logic tmo_inc,
  output logic req,
  output logic as,
  output logic wr,
  output logic rd,
  output logic ds,
  output logic oe,
  output logic done,
  output logic err
);
  import bm_pkg::*;

  bm_state_t st_q, st_d;
  logic is_wr_q;
  logic wr_ok_q;
  logic go_wr, go_rd;

  assign go_wr = (st_q == ST_IDLE) && start_wr;
  assign go_rd = (st_q == ST_IDLE) && !start_wr && start_rd && wr_ok_q;

  always_comb begin
    st_d    = st_q;
    idx_clr = 1'b0;
    idx_inc = 1'b0;
    tmo_clr = 1'b0;
    tmo_inc = 1'b0;
    case (st_q)
      ST_IDLE: if (go_wr || go_rd) begin
        st_d    = ST_REQ;
        idx_clr = 1'b1;
      end
      ST_REQ:  if (gnt) st_d = ST_ADDR;
      ST_ADDR: begin
        st_d    = ST_CMD;
        tmo_clr = 1'b1;
      end
      ST_CMD:  st_d = ST_STRB;
      ST_STRB: begin
        if (rdy) begin
          if (last) st_d = ST_IDLE;
          else begin
            st_d    = ST_NEXT;
            idx_inc = 1'b1;
          end
        end else if (tmo_hit) begin
          st_d = ST_IDLE;
        end else begin
          tmo_inc = 1'b1;
        end
      end
      ST_NEXT: st_d = ST_ADDR;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      is_wr_q <= 1'b0;
      wr_ok_q <= 1'b0;
      done    <= 1'b0;
      err     <= 1'b0;
    end else begin
      st_q <= st_d;
      if (go_wr || go_rd) begin
        is_wr_q <= go_wr;
        done    <= 1'b0;
        err     <= 1'b0;
        if (go_wr) wr_ok_q <= 1'b0;
      end
      if (st_q == ST_STRB) begin
        if (rdy) begin
          if (!is_wr_q && miss) err <= 1'b1;
          if (last) begin
            done <= 1'b1;
            if (is_wr_q) wr_ok_q <= 1'b1;
          end
        end else if (tmo_hit) begin
          done <= 1'b1;
          err  <= 1'b1;
          if (is_wr_q) wr_ok_q <= 1'b0;
        end
      end
    end
  end

  // Strobes decoded straight from the state flops.
  assign req = (st_q != ST_IDLE);
  assign as  = (st_q == ST_ADDR) || (st_q == ST_CMD) || (st_q == ST_STRB);
  assign wr  = is_wr_q  && ((st_q == ST_CMD) || (st_q == ST_STRB));
  assign rd  = !is_wr_q && ((st_q == ST_CMD) || (st_q == ST_STRB));
  assign ds  = (st_q == ST_STRB);
  assign oe  = is_wr_q && (st_q == ST_STRB);

endmodule

// File: rtl/dma_bus_master.sv
module dma_bus_master #(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int N_CYC  = 3,
  parameter int TMO    = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              do_write_i,
  input  logic              do_read_i,
  output logic              bus_req_o,
  input  logic              bus_gnt_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_out_o,
  input  logic [DATA_W-1:0] data_in_i,
  output logic              data_oe_o,
  output logic              as_o,
  output logic              wr_o,
  output logic              rd_o,
  output logic              ds_o,
  input  logic              rdy_i,
  output logic              done_o,
  output logic              err_o
);

  logic idx_clr, idx_inc, tmo_clr, tmo_inc;
  logic last, tmo_hit, miss;

  bm_ctrl u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start_wr (do_write_i),
    .start_rd (do_read_i),
    .gnt      (bus_gnt_i),
    .rdy      (rdy_i),
    .last     (last),
    .tmo_hit  (tmo_hit),
    .miss     (miss),
    .idx_clr  (idx_clr),
    .idx_inc  (idx_inc),
    .tmo_clr  (tmo_clr),
    .tmo_inc  (tmo_inc),
    .req      (bus_req_o),
    .as       (as_o),
    .wr       (wr_o),
    .rd       (rd_o),
    .ds       (ds_o),
    .oe       (data_oe_o),
    .done     (done_o),
    .err      (err_o)
  );

  bm_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .N_CYC  (N_CYC),
    .TMO    (TMO)
  ) u_dp (
    .clk     (clk),
    .rst     (rst),
    .idx_clr (idx_clr),
    .idx_inc (idx_inc),
    .tmo_clr (tmo_clr),
    .tmo_inc (tmo_inc),
    .data_in (data_in_i),
    .addr    (addr_o),
    .wdata   (data_out_o),
    .last    (last),
    .tmo_hit (tmo_hit),
    .miss    (miss)
  );

endmodule

// File: rtl/bm_checker.sv
module bm_checker #(
  parameter int ADDR_W    = 16,
  parameter int TMO       = 16,
  parameter int MEM_BYTES = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              bus_req_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic              data_oe_o,
  input logic              as_o,
  input logic              wr_o,
  input logic              rd_o,
  input logic              ds_o,
  input logic              rdy_i,
  input logic              done_o
);
  localparam int RUN_W = $clog2(TMO + 2);
  logic [RUN_W-1:0] run_q;

  // consecutive data-strobe clocks without ready
  always_ff @(posedge clk) begin
    if (rst) run_q <= '0;
    else if (ds_o && !rdy_i) run_q <= run_q + 1'b1;
    else run_q <= '0;
  end

  assert_strobe_needs_req_R1: assert property (@(posedge clk) disable iff (rst)
    (as_o || ds_o) |-> bus_req_o);
  assert_req_rise_no_as_R1: assert property (@(posedge clk) disable iff (rst)
    $rose(bus_req_o) |-> !as_o);
  assert_cmd_after_as_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(wr_o || rd_o) |-> as_o && $past(as_o));
  assert_ds_after_cmd_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(ds_o) |-> (wr_o || rd_o) && $past(wr_o || rd_o));
  assert_ds_hold_R2: assert property (@(posedge clk) disable iff (rst)
    (ds_o && !rdy_i) |=> (ds_o || done_o));
  assert_release_R3: assert property (@(posedge clk) disable iff (rst)
    (ds_o && rdy_i) |=> (!as_o && !ds_o && !wr_o && !rd_o));
  assert_oe_window_R4: assert property (@(posedge clk) disable iff (rst)
    data_oe_o |-> (ds_o && wr_o));
  assert_cmd_excl_R4: assert property (@(posedge clk) disable iff (rst)
    !(wr_o && rd_o));
  assert_addr_range_R7: assert property (@(posedge clk) disable iff (rst)
    as_o |-> (addr_o < ADDR_W'(MEM_BYTES)));
  assert_done_on_release_R8: assert property (@(posedge clk) disable iff (rst)
    $fell(bus_req_o) |-> done_o);
  assert_no_overrun_R9: assert property (@(posedge clk) disable iff (rst)
    ds_o |-> (run_q < RUN_W'(TMO)));

endmodule

bind dma_bus_master bm_checker #(
  .ADDR_W    (ADDR_W),
  .TMO       (TMO),
  .MEM_BYTES (64)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_req_o (bus_req_o),
  .addr_o    (addr_o),
  .data_oe_o (data_oe_o),
  .as_o      (as_o),
  .wr_o      (wr_o),
  .rd_o      (rd_o),
  .ds_o      (ds_o),
  .rdy_i     (rdy_i),
  .done_o    (done_o)
);

// File: tb/tb_dma_bus_master.sv
module tb_dma_bus_master;

  typedef struct {
    logic [15:0] addr;
    logic [7:0]  data;
    logic        is_wr;
  } xfer_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        do_write_i = 1'b0, do_read_i = 1'b0;
  logic        bus_req_o, bus_gnt_i = 1'b0;
  logic [15:0] addr_o;
  logic [7:0]  data_out_o, data_in_i;
  logic        data_oe_o, as_o, wr_o, rd_o, ds_o;
  logic        rdy_i = 1'b0;
  logic        done_o, err_o;

  int total = 0, bad = 0;
  xfer_t exp_q[$];

  // slave and arbiter knobs
  int  rdy_delay = 1, rdy_wait = 0, gnt_delay = 2, gnt_cnt = 0;
  bit  never_rdy = 0, corrupt_en = 0;
  logic [7:0] mem [64];
  int  n_xfer = 0, ds_run = 0, last_ds_run = 0, as_run = 0, cmd_run = 0;
  bit  prev_ds = 0, chk_release = 0;
  bit  finished = 0;

  always #4 clk = ~clk;

  dma_bus_master dut (
    .clk(clk), .rst(rst), .do_write_i(do_write_i), .do_read_i(do_read_i),
    .bus_req_o(bus_req_o), .bus_gnt_i(bus_gnt_i), .addr_o(addr_o),
    .data_out_o(data_out_o), .data_in_i(data_in_i), .data_oe_o(data_oe_o),
    .as_o(as_o), .wr_o(wr_o), .rd_o(rd_o), .ds_o(ds_o), .rdy_i(rdy_i),
    .done_o(done_o), .err_o(err_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", req, what, act, expv);
    end
  endtask

  // slave memory read path
  always_comb data_in_i = rd_o ? (mem[addr_o[5:0]] ^ ((corrupt_en && addr_o == 16'h12) ? 8'hFF : 8'h00)) : 8'h00;

  always @(posedge clk)
    if (ds_o && rdy_i && wr_o) mem[addr_o[5:0]] <= data_out_o;

  // slave ready and arbiter grant, driven at the falling edge
  always @(negedge clk) begin
    if (ds_o && !rdy_i) begin
      if (!never_rdy && rdy_wait >= rdy_delay) rdy_i <= 1'b1;
      else rdy_wait++;
    end else begin
      rdy_i <= 1'b0;
      rdy_wait = 0;
    end
    if (bus_req_o) begin
      gnt_cnt++;
      bus_gnt_i <= (gnt_cnt >= gnt_delay);
    end else begin
      gnt_cnt = 0;
      bus_gnt_i <= 1'b0;
    end
  end

  // monitor: scoreboard pop and per-cycle protocol checks
  always @(negedge clk) begin
    #1;
    if (!rst) begin
      if (chk_release) begin
        check(!as_o && !ds_o && !wr_o && !rd_o, "R3", "strobes after ready", {as_o, ds_o, wr_o, rd_o}, 0);
        chk_release = 0;
      end
      as_run  = as_o ? as_run + 1 : 0;
      cmd_run = (wr_o || rd_o) ? cmd_run + 1 : 0;
      if (ds_o && !prev_ds) begin
        check(as_run == 3 && cmd_run == 2, "R2", "as/cmd clocks at ds rise", as_run * 16 + cmd_run, 3 * 16 + 2);
      end
      if (ds_o) ds_run++;
      else if (prev_ds) begin
        last_ds_run = ds_run;
        ds_run = 0;
      end
      prev_ds = ds_o;
      if (ds_o && rdy_i) begin
        xfer_t e;
        n_xfer++;
        chk_release = 1;
        check(data_oe_o == wr_o, "R4", "output enable in data strobe", data_oe_o, wr_o);
        if (exp_q.size() == 0) begin
          check(0, "R5", "unexpected transfer", addr_o, 0);
        end else begin
          e = exp_q.pop_front();
          check(addr_o == e.addr, e.is_wr ? "R5" : "R6", "address", addr_o, e.addr);
          check(wr_o == e.is_wr, e.is_wr ? "R5" : "R6", "direction", wr_o, e.is_wr);
          if (e.is_wr) check(data_out_o == e.data, "R5", "write byte", data_out_o, e.data);
          check(addr_o < 64, "R7", "address range", addr_o, 63);
        end
      end
    end
  end

  task automatic push_batch(input bit is_wr);
    xfer_t e;
    logic [15:0] a[3] = '{16'h05, 16'h12, 16'h2A};
    logic [7:0]  d[3] = '{8'hA5, 8'h3C, 8'hF0};
    for (int i = 0; i < 3; i++) begin
      e.addr = a[i]; e.data = d[i]; e.is_wr = is_wr;
      exp_q.push_back(e);
    end
  endtask

  task automatic pulse(input bit is_wr);
    @(negedge clk);
    if (is_wr) do_write_i = 1'b1; else do_read_i = 1'b1;
    @(negedge clk);
    do_write_i = 1'b0; do_read_i = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    @(negedge clk);
    while (!done_o && n < 500) begin
      @(negedge clk);
      n++;
    end
    #2;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int n0;
    for (int i = 0; i < 64; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #2;
    // R11 reset state
    check(!bus_req_o && !as_o && !ds_o && !wr_o && !rd_o, "R11", "bus idle after reset", {bus_req_o, as_o, ds_o}, 0);
    check(!data_oe_o && !done_o && !err_o, "R11", "flags after reset", {data_oe_o, done_o, err_o}, 0);

    // R10 read trigger before any write batch
    pulse(0);
    repeat (8) @(negedge clk);
    #2;
    check(!bus_req_o && n_xfer == 0, "R10", "early read refused", n_xfer, 0);

    // R1 / R5 write batch with late grant
    gnt_delay = 6; rdy_delay = 1;
    push_batch(1);
    pulse(1);
    repeat (3) begin
      @(negedge clk); #2;
      check(bus_req_o && !as_o && !bus_gnt_i, "R1", "no strobe before grant", {bus_req_o, as_o}, 2);
    end
    wait_done();
    check(done_o && !err_o && !bus_req_o, "R8", "write batch end", {done_o, err_o, bus_req_o}, 4);
    check(exp_q.size() == 0 && n_xfer == 3, "R5", "write count", n_xfer, 3);
    check(mem[5] == 8'hA5 && mem[18] == 8'h3C && mem[42] == 8'hF0, "R5", "memory bytes", mem[18], 8'h3C);

    // R6 clean read-back, ready at once
    gnt_delay = 1; rdy_delay = 0;
    push_batch(0);
    pulse(0);
    wait_done();
    check(done_o && !err_o && !bus_req_o, "R6", "clean read-back", {done_o, err_o}, 2);
    check(exp_q.size() == 0 && n_xfer == 6, "R6", "read count", n_xfer, 6);

    // R6 corrupted byte detected
    corrupt_en = 1; rdy_delay = 2;
    push_batch(0);
    pulse(0);
    wait_done();
    check(done_o && err_o, "R6", "mismatch flagged", err_o, 1);
    corrupt_en = 0;

    // R8 new batch clears flags
    push_batch(0);
    pulse(0);
    #2;
    check(!done_o && !err_o, "R8", "flags cleared at start", {done_o, err_o}, 0);
    wait_done();
    check(!err_o, "R8", "error cleared for clean batch", err_o, 0);

    // R9 timeout on a write batch
    never_rdy = 1;
    n0 = n_xfer;
    pulse(1);
    wait_done();
    check(last_ds_run == 16, "R9", "data strobe clocks before abort", last_ds_run, 16);
    check(done_o && err_o && !bus_req_o, "R9", "abort flags", {done_o, err_o, bus_req_o}, 6);
    check(n_xfer == n0, "R9", "no completed transfer", n_xfer, n0);
    never_rdy = 0;

    // R10 read refused after timed-out write
    pulse(0);
    repeat (8) @(negedge clk);
    #2;
    check(!bus_req_o && n_xfer == n0, "R10", "read refused after abort", bus_req_o, 0);

    // recover with slow slave
    rdy_delay = 3;
    push_batch(1);
    pulse(1);
    wait_done();
    check(!err_o && exp_q.size() == 0, "R5", "rewrite with slow ready", err_o, 0);
    push_batch(0);
    pulse(0);
    wait_done();
    check(done_o && !err_o && exp_q.size() == 0, "R6", "read-back after rewrite", err_o, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule